// File: doc/BRIEF.md
# Neighbour-Compare Majority Fault Locator

This block watches N identical module instances that one shared generator drives with the same scan patterns at the same time. No expected response is stored anywhere. The instances are arranged in a ring, and each one is compared only with its two neighbours. An instance whose scan output differs from both neighbours is marked faulty in a per-instance fault word. Each cycle with any disagreement becomes an event. The event is registered first, then written into a small fault memory together with the cycle number at which the scan bits were sampled.

A small controller governs sampling through three states. ST_IDLE does not sample. ST_RUN samples every cycle. ST_FULL samples and counts events but no longer stores them. The transitions are: IDLE→RUN on `start`; RUN→FULL once the memory holds its last entry; any state→IDLE on `clear`. When two neighbouring instances fail together, the majority vote cannot name them. The block then stores the raw mismatch vector instead, marks the entry ambiguous and sets a sticky flag. Software reads the stored entries through a combinational read port.

Top module: `flt_majority_locator`

## Requirements
- R1: After reset the block is idle (`running`=0), `level`=0, `evt_count`=0, and `overflow` and `ambig_seen` are 0.
- R2: While idle, scan bits are not sampled: disagreeing inputs log nothing and change no counter.
- R3: Exactly one instance disagreeing with both of its neighbours produces an entry whose word has only bit i set (bit i = instance i), with the ambiguous bit 0.
- R4: The stamp stored with an entry is the cycle count of the sampling cycle. The count is 0 in the first sampled cycle after `start` and rises by 1 every sampled cycle.
- R5: A cycle in which all instances agree creates no event.
- R6: If some neighbours disagree but no instance disagrees with both of its neighbours, the entry is ambiguous (ambiguous bit 1). Its word is the mismatch vector, where bit k = instance k differs from instance (k+1) mod N, and `ambig_seen` becomes 1.
- R7: The ring wraps: instance 0 and instance N-1 are neighbours.
- R8: Two non-adjacent faulty instances give one entry with both of their bits set, not ambiguous.
- R9: The memory holds DEPTH (16) entries. Once full, further events are not stored, `level` stays at DEPTH and `overflow` becomes 1.
- R10: `evt_count` counts every event, including events after the memory is full, and saturates at its all-ones value.
- R11: `clear` returns the block to idle in one cycle. It zeroes the cycle count, `level`, `evt_count`, `overflow` and `ambig_seen`, and drops any event still in the pipeline.
- R12: An event sampled at clock edge E is visible in `level`, `evt_count` and the memory after edge E+1. `level` never rises by more than 1 per cycle.
- R13: `start` while running has no effect; the cycle count keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin sampling (effective only when idle) |
| clear | input | 1 | Synchronous return to idle, zeroing counters and flags |
| scan_bits | input | N_INST | One scan output bit per instance |
| rd_addr | input | $clog2(DEPTH) | Fault memory read address |
| rd_word | output | N_INST | Stored fault word, or mismatch vector if ambiguous |
| rd_stamp | output | STAMP_W | Stored cycle count |
| rd_ambig | output | 1 | Stored ambiguous marker |
| level | output | $clog2(DEPTH+1) | Number of entries written |
| evt_count | output | EVT_W | Saturating event count |
| overflow | output | 1 | An event arrived while the memory was full |
| ambig_seen | output | 1 | An ambiguous event has been logged |
| running | output | 1 | Controller is sampling (RUN or FULL) |

## Verification
The hardest state to reach is the saturated counter combined with a full memory. It needs far more than DEPTH events after the last stored entry. The stimulus holds one instance wrong for several hundred consecutive sampled cycles, so every cycle is an event. Ambiguous events and events at the ring seam come from adjacent pairs, including the pair made of instance N-1 and instance 0. A behavioural model compares against the design after every clock, so the pipeline delay between sample and write is checked on every event.

// File: rtl/flt_loc_pkg.sv
package flt_loc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FULL = 2'd2
    } loc_state_e;
endpackage

// File: rtl/flt_ring_compare.sv
module flt_ring_compare #(
    parameter int N_INST = 8
) (
    input  logic [N_INST-1:0] scan_bits,
    output logic [N_INST-1:0] mis_vec,
    output logic [N_INST-1:0] fault_vec,
    output logic              evt_hit,
    output logic              evt_ambig
);
    // mis_vec[k]: instance k versus instance k+1 (mod N)
    // fault_vec[i]: instance i disagrees with both neighbours
    for (genvar i = 0; i < N_INST; i++) begin : g_ring
        localparam int NXT = (i + 1) % N_INST;
        localparam int PRV = (i + N_INST - 1) % N_INST;
        assign mis_vec[i]   = scan_bits[i] ^ scan_bits[NXT];
        assign fault_vec[i] = mis_vec[PRV] & mis_vec[i];
    end

    assign evt_hit   = |mis_vec;
    assign evt_ambig = evt_hit & ~(|fault_vec);
endmodule

// File: rtl/flt_seq_ctrl.sv
module flt_seq_ctrl
    import flt_loc_pkg::*;
#(
    parameter int STAMP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               clear,
    input  logic               mem_full,
    output logic               running,
    output logic               sample_en,
    output logic [STAMP_W-1:0] cycle_cnt
);
    loc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start)    state_d = ST_RUN;
                ST_RUN:  if (mem_full) state_d = ST_FULL;
                ST_FULL: state_d = ST_FULL;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN, ST_FULL: begin
                running   = 1'b1;
                sample_en = 1'b1;
            end
            default: begin
                running   = 1'b0;
                sample_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cycle_cnt <= '0;
        else if (clear)     cycle_cnt <= '0;
        else if (sample_en) cycle_cnt <= cycle_cnt + 1'b1;
    end
endmodule

// File: rtl/flt_event_log.sv
module flt_event_log #(
    parameter int N_INST  = 8,
    parameter int DEPTH   = 16,
    parameter int STAMP_W = 16,
    parameter int EVT_W   = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               sample_en,
    input  logic [STAMP_W-1:0] cycle_cnt,
    input  logic [N_INST-1:0]  mis_vec,
    input  logic [N_INST-1:0]  fault_vec,
    input  logic               evt_hit,
    input  logic               evt_ambig,
    input  logic [AW-1:0]      rd_addr,
    output logic [N_INST-1:0]  rd_word,
    output logic [STAMP_W-1:0] rd_stamp,
    output logic               rd_ambig,
    output logic [LW-1:0]      level,
    output logic [EVT_W-1:0]   evt_count,
    output logic               overflow,
    output logic               ambig_seen,
    output logic               mem_full
);
    logic               cap_vld;
    logic [N_INST-1:0]  cap_word;
    logic [STAMP_W-1:0] cap_stamp;
    logic               cap_ambig;

    logic [N_INST-1:0]  mem_word  [DEPTH];
    logic [STAMP_W-1:0] mem_stamp [DEPTH];
    logic               mem_ambig [DEPTH];

    logic do_write;

    assign mem_full = (level == LW'(DEPTH));
    assign do_write = cap_vld && !mem_full && !clear;

    // capture stage: the event word is registered before it is stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vld   <= 1'b0;
            cap_word  <= '0;
            cap_stamp <= '0;
            cap_ambig <= 1'b0;
        end else if (clear) begin
            cap_vld   <= 1'b0;
        end else begin
            cap_vld   <= sample_en && evt_hit;
            cap_word  <= evt_ambig ? mis_vec : fault_vec;
            cap_stamp <= cycle_cnt;
            cap_ambig <= evt_ambig;
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) begin
            mem_word[level[AW-1:0]]  <= cap_word;
            mem_stamp[level[AW-1:0]] <= cap_stamp;
            mem_ambig[level[AW-1:0]] <= cap_ambig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level      <= '0;
            evt_count  <= '0;
            overflow   <= 1'b0;
            ambig_seen <= 1'b0;
        end else if (clear) begin
            level      <= '0;
            evt_count  <= '0;
            overflow   <= 1'b0;
            ambig_seen <= 1'b0;
        end else if (cap_vld) begin
            if (mem_full)            overflow  <= 1'b1;
            else                     level     <= level + 1'b1;
            if (evt_count != '1)     evt_count <= evt_count + 1'b1;
            if (cap_ambig)           ambig_seen <= 1'b1;
        end
    end

    assign rd_word  = mem_word[rd_addr];
    assign rd_stamp = mem_stamp[rd_addr];
    assign rd_ambig = mem_ambig[rd_addr];
endmodule

// File: rtl/flt_majority_locator.sv
module flt_majority_locator #(
    parameter int N_INST  = 8,
    parameter int DEPTH   = 16,
    parameter int STAMP_W = 16,
    parameter int EVT_W   = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               clear,
    input  logic [N_INST-1:0]  scan_bits,
    input  logic [AW-1:0]      rd_addr,
    output logic [N_INST-1:0]  rd_word,
    output logic [STAMP_W-1:0] rd_stamp,
    output logic               rd_ambig,
    output logic [LVL_W-1:0]   level,
    output logic [EVT_W-1:0]   evt_count,
    output logic               overflow,
    output logic               ambig_seen,
    output logic               running
);
    logic [N_INST-1:0]  mis_vec, fault_vec;
    logic               evt_hit, evt_ambig;
    logic               sample_en, mem_full;
    logic [STAMP_W-1:0] cycle_cnt;

    flt_ring_compare #(.N_INST(N_INST)) u_ring (
        .scan_bits (scan_bits),
        .mis_vec   (mis_vec),
        .fault_vec (fault_vec),
        .evt_hit   (evt_hit),
        .evt_ambig (evt_ambig)
    );

    flt_seq_ctrl #(.STAMP_W(STAMP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clear     (clear),
        .mem_full  (mem_full),
        .running   (running),
        .sample_en (sample_en),
        .cycle_cnt (cycle_cnt)
    );

    flt_event_log #(
        .N_INST (N_INST), .DEPTH(DEPTH), .STAMP_W(STAMP_W), .EVT_W(EVT_W)
    ) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .sample_en  (sample_en),
        .cycle_cnt  (cycle_cnt),
        .mis_vec    (mis_vec),
        .fault_vec  (fault_vec),
        .evt_hit    (evt_hit),
        .evt_ambig  (evt_ambig),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .rd_stamp   (rd_stamp),
        .rd_ambig   (rd_ambig),
        .level      (level),
        .evt_count  (evt_count),
        .overflow   (overflow),
        .ambig_seen (ambig_seen),
        .mem_full   (mem_full)
    );
endmodule

// File: rtl/flt_locator_checks.sv
module flt_locator_checks #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5,
    parameter int EVT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             running,
    input logic [LVL_W-1:0] level,
    input logic [EVT_W-1:0] evt_count,
    input logic             overflow,
    input logic             ambig_seen
);
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    a_r9_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (level == LVL_W'(DEPTH)));

    a_r11_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (level == '0 && evt_count == '0 && !overflow && !ambig_seen && !running));

    a_r10_evt_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (evt_count >= $past(evt_count)));

    a_r12_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (level == $past(level) || level == $past(level) + 1'b1));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clear) |=> ($stable(level) && $stable(evt_count)));
endmodule

bind flt_majority_locator flt_locator_checks #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .EVT_W(EVT_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .running    (running),
    .level      (level),
    .evt_count  (evt_count),
    .overflow   (overflow),
    .ambig_seen (ambig_seen)
);

// File: tb/tb_flt_majority_locator.sv
`timescale 1ns/1ps
module tb_flt_majority_locator;
    localparam int N   = 8;
    localparam int DEP = 16;
    localparam int SW  = 16;
    localparam int EW  = 8;
    localparam int EVT_MAX = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          clear = 1'b0;
    logic [N-1:0]  scan_bits = '0;
    logic [3:0]    rd_addr = '0;
    logic [N-1:0]  rd_word;
    logic [SW-1:0] rd_stamp;
    logic          rd_ambig;
    logic [4:0]    level;
    logic [EW-1:0] evt_count;
    logic          overflow, ambig_seen, running;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    flt_majority_locator #(.N_INST(N), .DEPTH(DEP), .STAMP_W(SW), .EVT_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
        .scan_bits(scan_bits), .rd_addr(rd_addr), .rd_word(rd_word),
        .rd_stamp(rd_stamp), .rd_ambig(rd_ambig), .level(level),
        .evt_count(evt_count), .overflow(overflow), .ambig_seen(ambig_seen),
        .running(running)
    );

    // ---------------- behavioural reference ----------------
    bit           m_active = 0;
    int           m_cnt = 0;
    bit           m_pend = 0;
    logic [N-1:0] m_pword = '0;
    int           m_pstamp = 0;
    bit           m_pamb = 0;
    int           m_evt = 0;
    bit           m_ovf = 0;
    bit           m_amb = 0;
    logic [N-1:0] q_word[$];
    int           q_stamp[$];
    bit           q_amb[$];

    function automatic void classify(input logic [N-1:0] v, output bit hit,
                                     output bit amb, output logic [N-1:0] w);
        logic [N-1:0] lone, diff;
        for (int i = 0; i < N; i++) begin
            bit left_d  = v[i] != v[(i + N - 1) % N];
            bit right_d = v[i] != v[(i + 1) % N];
            lone[i] = left_d && right_d;
            diff[i] = right_d;
        end
        hit = diff != 0;
        amb = hit && (lone == 0);
        w   = amb ? diff : lone;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active = 0; m_cnt = 0; m_pend = 0; m_evt = 0; m_ovf = 0; m_amb = 0;
            q_word.delete(); q_stamp.delete(); q_amb.delete();
        end else if (clear) begin
            m_active = 0; m_cnt = 0; m_pend = 0; m_evt = 0; m_ovf = 0; m_amb = 0;
            q_word.delete(); q_stamp.delete(); q_amb.delete();
        end else begin
            if (m_pend) begin
                if (m_evt < EVT_MAX) m_evt++;
                if (q_word.size() < DEP) begin
                    q_word.push_back(m_pword); q_stamp.push_back(m_pstamp); q_amb.push_back(m_pamb);
                end else m_ovf = 1;
                if (m_pamb) m_amb = 1;
            end
            m_pend = 0;
            if (m_active) begin
                bit h, a; logic [N-1:0] w;
                classify(scan_bits, h, a, w);
                m_pend = h; m_pword = w; m_pamb = a; m_pstamp = m_cnt;
                m_cnt = (m_cnt + 1) % (1 << SW);
            end
            if (start) m_active = 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 running",  running, m_active);
            chk("R12 level",   level, q_word.size());
            chk("R10 evt_count", evt_count, m_evt);
            chk("R9 overflow", overflow, m_ovf);
            chk("R6 ambig_seen", ambig_seen, m_amb);
        end
    end

    task automatic tick(logic [N-1:0] v, bit s = 0, bit c = 0);
        @(negedge clk);
        scan_bits = v; start = s; clear = c;
    endtask

    task automatic dump();
        for (int k = 0; k < q_word.size(); k++) begin
            rd_addr = 4'(k);
            #1;
            chk("R3 entry word",  rd_word,  q_word[k]);
            chk("R4/R13 entry stamp", rd_stamp, q_stamp[k]);
            chk("R6 entry ambig", rd_ambig, q_amb[k]);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 running", running, 0);
        chk("R1 level", level, 0);
        chk("R1 evt_count", evt_count, 0);
        chk("R1 flags", {overflow, ambig_seen}, 0);
        rst_n = 1'b1;

        // R2: disagreement while idle is ignored
        repeat (4) tick(8'h01);
        tick(8'h00);
        chk("R2 idle level", level, 0);

        tick(8'h00, 1);                 // start
        tick(8'h00); tick(8'h00);       // R5 agreement
        tick(8'h08);                    // R3 single fault, instance 3
        tick(8'hF7);                    // R3 complement form, instance 3
        tick(8'h00, 1);                 // R13 start while running
        tick(8'h01);                    // R7 instance 0
        tick(8'h80);                    // R7 instance 7
        tick(8'h18);                    // R6 adjacent 3,4 -> mismatch bits 2,4
        tick(8'h81);                    // R6/R7 adjacent 7,0 -> mismatch bits 6,0
        tick(8'h22);                    // R8 non-adjacent 1,5
        tick(8'hFF); tick(8'hFF); tick(8'h00);
        chk("R5 quiet level", level, 7);
        chk("R6 ambig flag", ambig_seen, 1);
        dump();
        rd_addr = 4'd5; #1;
        chk("R6 seam mismatch word", rd_word, 8'h41);
        rd_addr = 4'd6; #1;
        chk("R8 two faults word", rd_word, 8'h22);

        // R9/R10: fill, overflow and saturate
        repeat (300) tick(8'h10);
        repeat (3) tick(8'h00);
        chk("R9 level full", level, DEP);
        chk("R9 overflow set", overflow, 1);
        chk("R10 saturated", evt_count, EVT_MAX);
        dump();

        // R11: clear in one cycle, then restart from stamp 0
        tick(8'h00, 0, 1);
        tick(8'h00);
        chk("R11 idle", running, 0);
        chk("R11 level", level, 0);
        chk("R11 evt_count", evt_count, 0);
        chk("R11 flags", {overflow, ambig_seen}, 0);
        tick(8'h00, 1);
        tick(8'h40);
        tick(8'h00); tick(8'h00);
        rd_addr = 4'd0; #1;
        chk("R11 restart stamp", rd_stamp, 0);
        chk("R3 restart word", rd_word, 8'h40);
        dump();

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule